// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out how each of two address-select pins is wired. A pin can be tied low, tied high, connected to the serial clock line or connected to the serial data line. From that four-way class per pin it forms the four low bits of a slave address. It also forms a power-up default pattern and a pullup-enable pattern for sixteen ports, which are set in groups of `GRP_W`.

The block watches the already-synchronized clock and data lines for START and STOP conditions. Between a START and the matching STOP it compares each pin against both bus lines on every cycle. Every framed transmission refreshes the result, whatever address that transmission targets. The new result takes effect only at the STOP.

Until the first complete transmission after reset, each pin is judged by its live static level. The bus idles high, so pins tied to a bus line read as tied high in that phase. The outputs are plain level signals. There is no handshake, because the consumer simply samples them.

Top module: `adp_addr_decoder`

## Requirements
- R1: `addr_o[1:0]` encodes the first pin (`pin_a_i`) as tied-low=00, tied-high=01, clock-line=10, data-line=11.
- R2: `addr_o[3:2]` encodes the second pin (`pin_b_i`) as clock-line=00, data-line=01, tied-low=10, tied-high=11.
- R3: The first pin drives bits `[GRP_W-1:0]` of `io_dflt_o`, `io_pull_o` and `out_dflt_o`, and the second pin drives bits `[2*GRP_W-1:GRP_W]`. A group is all ones for any class other than tied-low and all zeros for tied-low, and `io_pull_o` always equals `io_dflt_o`.
- R4: A pin is classed as following a bus line only if three things hold within one transmission: it equalled that line while the line was low, it equalled that line while the line was high, and it never differed from it. The clock line wins if both lines qualify. Otherwise the pin's level in the STOP cycle picks tied-high or tied-low.
- R5: Once a transmission has completed, the outputs change only in the cycle right after a STOP that closes a framed transmission. They never change between a START and its STOP.
- R6: Before the first completed transmission after reset, each pin is classed from its live level (high = tied-high, low = tied-low), and the outputs follow that level combinationally.
- R7: Every framed transmission refreshes both classes, whatever byte it carries. A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high.
- R8: A STOP with no START before it leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| pin_a_i | input | 1 | Synchronized level of the first address pin |
| pin_b_i | input | 1 | Synchronized level of the second address pin |
| addr_o | output | 4 | Decoded low slave-address bits |
| io_dflt_o | output | 2*GRP_W | Default levels for the open-drain port group |
| io_pull_o | output | 2*GRP_W | Pullup enables for the open-drain port group |
| out_dflt_o | output | 2*GRP_W | Default levels for the push-pull port group |

## Verification
Two things meet in the STOP cycle: the last correlation sample is taken, and the new class is committed. The bench provokes this by changing a static pin's level on exactly the edge where SDA rises for the STOP. It then expects the class to follow the new level rather than the level held during the byte. A second case starts a transmission with new pin wiring and samples the outputs before its STOP. Those outputs must still show the previous result, and the new one must appear on the cycle after the STOP.

// File: rtl/adp_pkg.sv
package adp_pkg;

  typedef enum logic [1:0] {
    PC_GND = 2'd0,
    PC_VCC = 2'd1,
    PC_SCL = 2'd2,
    PC_SDA = 2'd3
  } pin_class_e;

  // Low address pair code: same numbering as the enum.
  function automatic logic [1:0] lo_code(pin_class_e c);
    return 2'(c);
  endfunction

  // High address pair code.
  function automatic logic [1:0] hi_code(pin_class_e c);
    case (c)
      PC_SCL:  return 2'b00;
      PC_SDA:  return 2'b01;
      PC_GND:  return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/adp_frame_det.sv
module adp_frame_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic commit_o,
  output logic in_xfer_o,
  output logic committed_o
);
  logic scl_q, sda_q, busy_q, done_q;

  assign start_o     = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o      = scl_i & scl_q & ~sda_q & sda_i;
  assign commit_o    = stop_o & busy_q;
  assign in_xfer_o   = busy_q;
  assign committed_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_o)     busy_q <= 1'b1;
      else if (stop_o) busy_q <= 1'b0;
      if (commit_o)    done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adp_pin_classifier.sv
module adp_pin_classifier
  import adp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       start_i,
  input  logic       in_xfer_i,
  input  logic       commit_i,
  output pin_class_e cls_o
);
  typedef struct packed {
    logic lo;
    logic hi;
    logic miss;
  } track_t;

  track_t trk_scl_q, trk_sda_q, trk_scl_n, trk_sda_n, smp_scl, smp_sda;
  pin_class_e cls_q, cls_n;

  function automatic track_t sample(logic line, logic pin);
    track_t t;
    t.lo   = ~line & ~pin;
    t.hi   = line & pin;
    t.miss = line ^ pin;
    return t;
  endfunction

  function automatic logic follows(track_t t);
    return t.lo & t.hi & ~t.miss;
  endfunction

  always_comb begin
    smp_scl = sample(scl_i, pin_i);
    smp_sda = sample(sda_i, pin_i);
    if (start_i) begin
      trk_scl_n = smp_scl;
      trk_sda_n = smp_sda;
    end else if (in_xfer_i) begin
      trk_scl_n = trk_scl_q | smp_scl;
      trk_sda_n = trk_sda_q | smp_sda;
    end else begin
      trk_scl_n = trk_scl_q;
      trk_sda_n = trk_sda_q;
    end
    if (follows(trk_scl_n))      cls_n = PC_SCL;
    else if (follows(trk_sda_n)) cls_n = PC_SDA;
    else if (pin_i)              cls_n = PC_VCC;
    else                         cls_n = PC_GND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_scl_q <= '0;
      trk_sda_q <= '0;
      cls_q     <= PC_VCC;
    end else begin
      trk_scl_q <= trk_scl_n;
      trk_sda_q <= trk_sda_n;
      if (commit_i) cls_q <= cls_n;
    end
  end

  assign cls_o = cls_q;
endmodule

// File: rtl/adp_group_map.sv
module adp_group_map
  import adp_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int NPIN  = 2
) (
  input  pin_class_e              cls_i [NPIN],
  output logic [3:0]              addr_o,
  output logic [NPIN*GRP_W-1:0]   io_dflt_o,
  output logic [NPIN*GRP_W-1:0]   io_pull_o,
  output logic [NPIN*GRP_W-1:0]   out_dflt_o
);
  assign addr_o = {hi_code(cls_i[1]), lo_code(cls_i[0])};

  for (genvar g = 0; g < NPIN; g++) begin : g_grp
    logic up;
    assign up = (cls_i[g] != PC_GND);
    assign io_dflt_o[g*GRP_W +: GRP_W]  = {GRP_W{up}};
    assign io_pull_o[g*GRP_W +: GRP_W]  = {GRP_W{up}};
    assign out_dflt_o[g*GRP_W +: GRP_W] = {GRP_W{up}};
  end
endmodule

// File: rtl/adp_addr_decoder.sv
module adp_addr_decoder
  import adp_pkg::*;
#(
  parameter int GRP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               pin_a_i,
  input  logic               pin_b_i,
  output logic [3:0]         addr_o,
  output logic [2*GRP_W-1:0] io_dflt_o,
  output logic [2*GRP_W-1:0] io_pull_o,
  output logic [2*GRP_W-1:0] out_dflt_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins;
  logic start_evt, stop_evt, commit_evt, in_xfer, committed;
  pin_class_e cls_reg [NPIN];
  pin_class_e cls_eff [NPIN];

  assign pins = {pin_b_i, pin_a_i};

  adp_frame_det u_frame (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_evt), .stop_o(stop_evt), .commit_o(commit_evt),
    .in_xfer_o(in_xfer), .committed_o(committed)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    adp_pin_classifier u_cls (
      .clk(clk), .rst_n(rst_n), .pin_i(pins[p]), .scl_i(scl_i),
      .sda_i(sda_i), .start_i(start_evt), .in_xfer_i(in_xfer),
      .commit_i(commit_evt), .cls_o(cls_reg[p])
    );
    // Live static level until a transmission has completed.
    assign cls_eff[p] = committed ? cls_reg[p] : (pins[p] ? PC_VCC : PC_GND);
  end

  adp_group_map #(.GRP_W(GRP_W), .NPIN(NPIN)) u_map (
    .cls_i(cls_eff), .addr_o(addr_o), .io_dflt_o(io_dflt_o),
    .io_pull_o(io_pull_o), .out_dflt_o(out_dflt_o)
  );
endmodule

// File: rtl/adp_addr_decoder_chk.sv
module adp_addr_decoder_chk #(
  parameter int GRP_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pin_a_i,
  input logic               committed,
  input logic               in_xfer,
  input logic               stop_evt,
  input logic               commit_evt,
  input logic [3:0]         addr_o,
  input logic [2*GRP_W-1:0] io_dflt_o,
  input logic [2*GRP_W-1:0] io_pull_o,
  input logic [2*GRP_W-1:0] out_dflt_o
);
  // R1
  a1a0_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o[1:0] == 2'b00) == (io_pull_o[GRP_W-1:0] == '0));

  // R2
  a3a2_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o[3:2] == 2'b10) == (out_dflt_o[2*GRP_W-1:GRP_W] == '0));

  // R3
  groups_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_pull_o == io_dflt_o) && (io_dflt_o == out_dflt_o));

  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (committed && !commit_evt) |=> $stable(addr_o));

  // R6
  live_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !committed |-> (addr_o[1:0] == (pin_a_i ? 2'b01 : 2'b00)));

  // R8
  orphan_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (committed && stop_evt && !in_xfer) |=> $stable(addr_o));
endmodule

bind adp_addr_decoder adp_addr_decoder_chk #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a_i), .committed(committed),
  .in_xfer(in_xfer), .stop_evt(stop_evt), .commit_evt(commit_evt),
  .addr_o(addr_o), .io_dflt_o(io_dflt_o), .io_pull_o(io_pull_o),
  .out_dflt_o(out_dflt_o)
);

// File: tb/adp_addr_decoder_bench.sv
module adp_addr_decoder_bench;
  localparam int GRP_W = 4;
  // modes: 0 tied low, 1 tied high, 2 clock line, 3 data line
  localparam logic [11:0] VEC [16] = '{
    {2'd0, 2'd0, 8'hA5}, {2'd0, 2'd1, 8'h3C}, {2'd0, 2'd2, 8'h5A}, {2'd0, 2'd3, 8'h81},
    {2'd1, 2'd0, 8'h7E}, {2'd1, 2'd1, 8'h00}, {2'd1, 2'd2, 8'hFF}, {2'd1, 2'd3, 8'h96},
    {2'd2, 2'd0, 8'h42}, {2'd2, 2'd1, 8'hC3}, {2'd2, 2'd2, 8'h18}, {2'd2, 2'd3, 8'hE7},
    {2'd3, 2'd0, 8'h6B}, {2'd3, 2'd1, 8'h94}, {2'd3, 2'd2, 8'h0F}, {2'd3, 2'd3, 8'hF0}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1, pin_a = 1'b1, pin_b = 1'b1;
  logic [3:0] addr;
  logic [2*GRP_W-1:0] io_dflt, io_pull, out_dflt;
  logic [1:0] mode_a = 2'd1, mode_b = 2'd1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adp_addr_decoder #(.GRP_W(GRP_W)) u_adp_addr_decoder (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .pin_a_i(pin_a),
    .pin_b_i(pin_b), .addr_o(addr), .io_dflt_o(io_dflt), .io_pull_o(io_pull),
    .out_dflt_o(out_dflt)
  );

  function automatic logic pv(logic [1:0] m, logic s, logic d);
    case (m)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return s;
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] exp_addr(logic [1:0] ma, logic [1:0] mb);
    logic [1:0] hi;
    case (mb)
      2'd0: hi = 2'b10;
      2'd1: hi = 2'b11;
      2'd2: hi = 2'b00;
      default: hi = 2'b01;
    endcase
    return {hi, ma};
  endfunction

  function automatic logic [7:0] exp_grp(logic [1:0] ma, logic [1:0] mb);
    return {(mb == 2'd0) ? 4'h0 : 4'hF, (ma == 2'd0) ? 4'h0 : 4'hF};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(logic s, logic d);
    @(negedge clk);
    scl = s; sda = d;
    pin_a = pv(mode_a, s, d);
    pin_b = pv(mode_b, s, d);
  endtask

  task automatic xfer_begin(logic [7:0] b);
    bus(1'b1, 1'b1);
    bus(1'b1, 1'b0);
    for (int i = 7; i >= -1; i--) begin
      logic bit_v;
      bit_v = (i >= 0) ? b[i] : 1'b0;
      bus(1'b0, bit_v);
      bus(1'b1, bit_v);
      bus(1'b0, bit_v);
    end
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_all(string req, logic [1:0] ma, logic [1:0] mb);
    chk(req, 8'(addr), 8'(exp_addr(ma, mb)));
    chk(req, io_dflt, exp_grp(ma, mb));
    chk(req, {io_pull ^ io_dflt} | {out_dflt ^ io_dflt}, 8'h00);
  endtask

  initial begin
    // Reset with first pin tied low and second on the clock line.
    mode_a = 2'd0; mode_b = 2'd2;
    pin_a = 1'b0; pin_b = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R6 reset live addr", 8'(addr), 8'h0C);
    chk("R3 reset groups", io_dflt, 8'hF0);

    // Live path before any transmission.
    mode_a = 2'd1;
    bus(1'b1, 1'b1);
    #1;
    chk("R6 live pin change", 8'(addr), 8'h0D);

    // Table of all sixteen wirings.
    for (int i = 0; i < 16; i++) begin
      mode_b = VEC[i][11:10];
      mode_a = VEC[i][9:8];
      xfer_begin(VEC[i][7:0]);
      bus(1'b1, 1'b1);
      settle();
      check_all("R1 R2 R3 R4 R7 table", VEC[i][9:8], VEC[i][11:10]);
    end

    // R5: rewire, sample mid transmission, then after STOP.
    mode_a = 2'd0; mode_b = 2'd2;
    xfer_begin(8'h5A);
    #1;
    chk("R5 held mid transmission", 8'(addr), 8'(exp_addr(2'd3, 2'd3)));
    bus(1'b1, 1'b1);
    settle();
    chk("R5 updated after stop", 8'(addr), 8'(exp_addr(2'd0, 2'd2)));

    // R4: static pin changes level exactly in the STOP cycle.
    mode_a = 2'd0; mode_b = 2'd1;
    xfer_begin(8'h3C);
    mode_a = 2'd1;
    bus(1'b1, 1'b1);
    settle();
    chk("R4 level at stop cycle", 8'(addr), 8'h0D);
    chk("R4 groups at stop cycle", io_dflt, 8'hFF);

    // R8: STOP without START.
    mode_a = 2'd0;
    bus(1'b0, 1'b1);
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
    bus(1'b1, 1'b1);
    settle();
    chk("R8 orphan stop addr", 8'(addr), 8'h0D);
    chk("R8 orphan stop groups", out_dflt, 8'hFF);

    // Reset returns to the live phase, then a fresh transmission.
    mode_a = 2'd0; mode_b = 2'd3;
    bus(1'b1, 1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R6 live after reset", 8'(addr), 8'h0C);
    xfer_begin(8'hC3);
    bus(1'b1, 1'b1);
    settle();
    chk("R7 data-line pin after reset", 8'(addr), 8'h04);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule